// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block picks which pending interrupt line to offer to a processor core and decides whether that interrupt is urgent enough to preempt the handler that is running. Each line has an 8-bit priority register. Only the top `PRIO_BITS` bits of the register are implemented, and a smaller number means more urgent. A grouping field splits the byte in two. The upper part is the preempt level and the lower part is a subpriority that only breaks ties. Two controls sit in front of delivery: a global disable bit, and a threshold register that uses the same left-aligned encoding as the priority registers.

The block keeps a stack of the preempt levels of the handlers that are running. An entry acknowledge from the core accepts the interrupt on offer. The block then pushes the current level and makes the preempt level of the accepted interrupt the current one. An exit acknowledge pops the stack and restores the level that was current before. When no handler is active, the current level is one step less urgent than any value a register can hold, so any unmasked pending line can be taken.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset, every priority register reads 0, `takeReq` is 0 and no handler is active.
- R2: A priority write stores only the top `PRIO_BITS` bits of the byte. The lower `8-PRIO_BITS` bits always read as 0, and the bits written there are dropped.
- R3: A line is a candidate when its pending and enable bits are both 1. Among the candidates, the offered line is the one with the smallest full priority byte. Smallest preempt part wins first, then smallest subpriority, then lowest ID. The same value may be shared by several lines.
- R4: `groupSel` = g makes the low g bits of the priority byte the subpriority and bits 7..g the preempt level. The winner is offered only when its preempt level is strictly less than the current active level. With g = 0 all bits are preempt.
- R5: A winner whose preempt level equals the active level is not offered, even when its subpriority is smaller than the subpriority of the running handler.
- R6: While `globalMask` is 1, `takeReq` stays 0.
- R7: Let T be `thresh` with its unimplemented low bits cleared. When T is nonzero, a line whose priority byte is greater than or equal to T is not a candidate. When T is 0, the threshold blocks nothing.
- R8: With no handler active, the winner is offered whatever its preempt level.
- R9: `entryAck`, given while `takeReq` is 1, makes the preempt level of `takePrio` the active level. The previous level is pushed onto the stack, and `takeReq` is 0 in the following cycle.
- R10: `exitAck` restores the level that was active before the most recent entry that is still open. With an empty stack, the block returns to the idle state.
- R11: `takeReq`, `takeId` and `takePrio` are registered. They reflect the inputs and the active level as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqPending | input | NUM_IRQ | Pending bit per line |
| irqEnable | input | NUM_IRQ | Enable bit per line |
| prioWrEn | input | 1 | Priority register write strobe |
| prioWrId | input | ID_W | Line whose priority register is written |
| prioWrData | input | 8 | Priority byte to write |
| prioRdId | input | ID_W | Line whose priority register is read |
| prioRdData | output | 8 | Priority byte of line `prioRdId` |
| groupSel | input | 3 | Number of low bits that form the subpriority |
| globalMask | input | 1 | Blocks all delivery while 1 |
| thresh | input | 8 | Threshold byte, left-aligned; effective value 0 disables it |
| entryAck | input | 1 | Core accepted the offered interrupt |
| exitAck | input | 1 | Core left the innermost handler |
| takeReq | output | 1 | An interrupt is offered |
| takeId | output | ID_W | ID of the offered line |
| takePrio | output | 8 | Priority byte of the offered line |

## Verification
The assertions assume that the core raises `entryAck` only in a cycle where `takeReq` is 1 and never raises it together with `exitAck`. Under those conditions the active levels on the stack form a strictly decreasing chain that fits in the stack. The stimulus keeps within these limits: acknowledges are driven only after the bench has seen an offer, and an exit is never paired with an entry. The grouping field is held steady while handlers are nested, so the stack depth never exceeds the number of implemented levels. The sweeps run with no handler active and vary the pending mask across all of its values under several priority, grouping, threshold and disable settings.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic offer;   // winner may be presented this cycle
    logic squash;  // core is accepting: suppress the next presentation
  } nestStrobe_t;

  // Left-aligned mask of the implemented priority bits.
  function automatic logic [7:0] implMaskOf(input int bits);
    return 8'hFF << (8 - bits);
  endfunction

  // Mask that keeps the preempt part for a given subpriority width.
  function automatic logic [7:0] preemptMaskOf(input logic [2:0] subBits);
    return 8'hFF << subBits;
  endfunction

endpackage

// File: rtl/irq_nest_dp.sv
module irq_nest_dp
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  localparam int ID_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic              prioWrEn,
  input  logic [ID_W-1:0]   prioWrId,
  input  logic [7:0]        prioWrData,
  input  logic [ID_W-1:0]   prioRdId,
  output logic [7:0]        prioRdData,
  input  logic [7:0]        thresh,
  input  nestStrobe_t       strobe,
  output logic              anyElig,
  output logic [7:0]        winPrio,
  output logic              takeReq,
  output logic [ID_W-1:0]   takeId,
  output logic [7:0]        takePrio
);

  localparam logic [7:0] IMPL_MASK = implMaskOf(PRIO_BITS);

  logic [7:0] prioBank [NUM_IRQ];
  logic [NUM_IRQ-1:0] elig;
  logic [7:0] thrEff;
  logic thrOn;

  assign thrEff = thresh & IMPL_MASK;
  assign thrOn  = (thrEff != 8'h00);

  // Priority register bank: one register per line, low bits never stored.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioBank[i] <= 8'h00;
      end else if (prioWrEn && ({1'b0, prioWrId} == (ID_W+1)'(i))) begin
        prioBank[i] <= prioWrData & IMPL_MASK;
      end
    end
    assign elig[i] = irqPending[i] && irqEnable[i] &&
                     !(thrOn && (prioBank[i] >= thrEff));
  end

  always_comb begin
    prioRdData = 8'h00;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if ({1'b0, prioRdId} == (ID_W+1)'(k)) prioRdData = prioBank[k];
    end
  end

  // Linear selection chain: a later line replaces the best so far only
  // when strictly smaller, so equal values keep the lower ID.
  logic            chainVld  [NUM_IRQ+1];
  logic [7:0]      chainPrio [NUM_IRQ+1];
  logic [ID_W-1:0] chainId   [NUM_IRQ+1];

  assign chainVld[0]  = 1'b0;
  assign chainPrio[0] = 8'h00;
  assign chainId[0]   = '0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chain
    logic replace;
    assign replace        = elig[i] && (!chainVld[i] || (prioBank[i] < chainPrio[i]));
    assign chainVld[i+1]  = chainVld[i] || elig[i];
    assign chainPrio[i+1] = replace ? prioBank[i] : chainPrio[i];
    assign chainId[i+1]   = replace ? ID_W'(i) : chainId[i];
  end

  assign anyElig = chainVld[NUM_IRQ];
  assign winPrio = chainPrio[NUM_IRQ];

  // Presentation registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeReq  <= 1'b0;
      takeId   <= '0;
      takePrio <= 8'h00;
    end else begin
      takeReq <= strobe.offer && !strobe.squash;
      if (strobe.offer) begin
        takeId   <= chainId[NUM_IRQ];
        takePrio <= chainPrio[NUM_IRQ];
      end
    end
  end

endmodule

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl
  import irq_nest_pkg::*;
#(
  parameter int NEST_DEPTH = 8,
  localparam int SP_W  = $clog2(NEST_DEPTH + 1),
  localparam int IDX_W = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        entryAck,
  input  logic        exitAck,
  input  logic [2:0]  groupSel,
  input  logic        globalMask,
  input  logic        anyElig,
  input  logic [7:0]  winPrio,
  input  logic [7:0]  takePrio,
  output nestStrobe_t strobe,
  output logic [8:0]  curLevel
);

  localparam logic [8:0] IDLE_LEVEL = 9'h100;

  logic [8:0]      levelStack [NEST_DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] spDec;
  logic [7:0]      preMask;
  logic [8:0]      winPre;
  logic [8:0]      acceptPre;

  assign preMask   = preemptMaskOf(groupSel);
  assign winPre    = {1'b0, winPrio & preMask};
  assign acceptPre = {1'b0, takePrio & preMask};
  assign spDec     = sp - 1'b1;

  always_comb begin
    strobe.offer  = anyElig && !globalMask && (winPre < curLevel);
    strobe.squash = entryAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp       <= '0;
      curLevel <= IDLE_LEVEL;
      for (int k = 0; k < NEST_DEPTH; k++) levelStack[k] <= IDLE_LEVEL;
    end else if (entryAck) begin
      if (sp < SP_W'(NEST_DEPTH)) begin
        levelStack[sp[IDX_W-1:0]] <= curLevel;
        sp       <= sp + 1'b1;
        curLevel <= acceptPre;
      end
    end else if (exitAck) begin
      if (sp != '0) begin
        sp       <= spDec;
        curLevel <= levelStack[spDec[IDX_W-1:0]];
      end else begin
        curLevel <= IDLE_LEVEL;
      end
    end
  end

endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int PRIO_BITS  = 3,
  parameter int NEST_DEPTH = 8,
  localparam int ID_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic               prioWrEn,
  input  logic [ID_W-1:0]    prioWrId,
  input  logic [7:0]         prioWrData,
  input  logic [ID_W-1:0]    prioRdId,
  output logic [7:0]         prioRdData,
  input  logic [2:0]         groupSel,
  input  logic               globalMask,
  input  logic [7:0]         thresh,
  input  logic               entryAck,
  input  logic               exitAck,
  output logic               takeReq,
  output logic [ID_W-1:0]    takeId,
  output logic [7:0]         takePrio
);

  nestStrobe_t strobe;
  logic        anyElig;
  logic [7:0]  winPrio;
  logic [8:0]  curLevel;

  irq_nest_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_dp (
    .clk(clk), .rstN(rstN),
    .irqPending(irqPending), .irqEnable(irqEnable),
    .prioWrEn(prioWrEn), .prioWrId(prioWrId), .prioWrData(prioWrData),
    .prioRdId(prioRdId), .prioRdData(prioRdData),
    .thresh(thresh), .strobe(strobe),
    .anyElig(anyElig), .winPrio(winPrio),
    .takeReq(takeReq), .takeId(takeId), .takePrio(takePrio)
  );

  irq_nest_ctl #(.NEST_DEPTH(NEST_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN),
    .entryAck(entryAck), .exitAck(exitAck),
    .groupSel(groupSel), .globalMask(globalMask),
    .anyElig(anyElig), .winPrio(winPrio), .takePrio(takePrio),
    .strobe(strobe), .curLevel(curLevel)
  );

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  localparam int ID_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_IRQ-1:0] irqPending,
  input logic [NUM_IRQ-1:0] irqEnable,
  input logic [7:0]         prioRdData,
  input logic [2:0]         groupSel,
  input logic               globalMask,
  input logic [7:0]         thresh,
  input logic               entryAck,
  input logic               takeReq,
  input logic [ID_W-1:0]    takeId,
  input logic [7:0]         takePrio,
  input logic [8:0]         curLevel
);

  localparam logic [7:0] IMPL_MASK = implMaskOf(PRIO_BITS);

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((prioRdData & ~IMPL_MASK) == 8'h00) && ((takePrio & ~IMPL_MASK) == 8'h00)); // R2

  AST_TAKE_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> ((($past(irqPending & irqEnable) >> takeId) & NUM_IRQ'(1)) != '0)); // R3

  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> ({1'b0, takePrio & preemptMaskOf($past(groupSel))} < $past(curLevel))); // R4

  AST_GLOBAL_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> !$past(globalMask)); // R6

  AST_THRESH_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && ($past(thresh & IMPL_MASK) != 8'h00)) |-> (takePrio < $past(thresh & IMPL_MASK))); // R7

  AST_ACK_SQUASH: assert property (@(posedge clk) disable iff (!rstN)
    entryAck |=> !takeReq); // R9

endmodule

bind irq_nest_arbiter irq_nest_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_chk (.*);

// File: tb/sim_irq_nest_arbiter.sv
`timescale 1ns/1ps
module sim_irq_nest_arbiter;

  localparam int N = 8;
  localparam logic [7:0] IMPL = 8'hE0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] irqPending = '0, irqEnable = '0;
  logic prioWrEn = 1'b0;
  logic [2:0] prioWrId = '0, prioRdId = '0;
  logic [7:0] prioWrData = '0;
  logic [7:0] prioRdData;
  logic [2:0] groupSel = '0;
  logic globalMask = 1'b0;
  logic [7:0] thresh = '0;
  logic entryAck = 1'b0, exitAck = 1'b0;
  logic takeReq;
  logic [2:0] takeId;
  logic [7:0] takePrio;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] pm [N];

  always #2.5 clk = ~clk;

  irq_nest_arbiter u0 (
    .clk(clk), .rstN(rstN), .irqPending(irqPending), .irqEnable(irqEnable),
    .prioWrEn(prioWrEn), .prioWrId(prioWrId), .prioWrData(prioWrData),
    .prioRdId(prioRdId), .prioRdData(prioRdData), .groupSel(groupSel),
    .globalMask(globalMask), .thresh(thresh), .entryAck(entryAck),
    .exitAck(exitAck), .takeReq(takeReq), .takeId(takeId), .takePrio(takePrio)
  );

  task automatic expectOut(input string req, input logic eTake, input int eId,
                           input logic [7:0] ePrio);
    checks++;
    if (takeReq !== eTake || (eTake && (int'(takeId) != eId || takePrio !== ePrio))) begin
      errors++;
      $display("FAIL %s: take=%0b id=%0d prio=%02h expected take=%0b id=%0d prio=%02h",
               req, takeReq, takeId, takePrio, eTake, eId, ePrio);
    end
  endtask

  task automatic writePrio(input int id, input logic [7:0] d);
    @(negedge clk);
    prioWrEn = 1'b1; prioWrId = 3'(id); prioWrData = d;
    @(negedge clk);
    prioWrEn = 1'b0;
    pm[id] = d & IMPL;
  endtask

  // Expected offer, computed from the requirements.
  task automatic model(input logic [8:0] lvl, output logic t, output int id,
                       output logic [7:0] p);
    int best = -1;
    logic [7:0] thr = thresh & IMPL;
    p = 8'h00;
    for (int i = 0; i < N; i++) begin
      if (irqPending[i] && irqEnable[i] && !(thr != 0 && pm[i] >= thr)) begin
        if (best < 0 || pm[i] < p) begin best = i; p = pm[i]; end
      end
    end
    id = best;
    t = (best >= 0) && !globalMask && ({1'b0, p & (8'hFF << groupSel)} < lvl);
  endtask

  task automatic sweep(input string req, input logic [N-1:0] en);
    logic t; int id; logic [7:0] p;
    irqEnable = en;
    for (int m = 0; m < 256; m++) begin
      @(negedge clk);
      irqPending = 8'(m);
      @(negedge clk);
      model(9'h100, t, id, p);
      expectOut(req, t, id, p);
    end
  endtask

  task automatic setPend(input logic [N-1:0] v);
    @(negedge clk); irqPending = v; @(negedge clk);
  endtask

  task automatic pulseEntry;
    @(negedge clk); entryAck = 1'b1;
    @(negedge clk); entryAck = 1'b0;
    expectOut("R9 squash after entry", 1'b0, 0, 8'h00);
  endtask

  task automatic pulseExit;
    @(negedge clk); exitAck = 1'b1;
    @(negedge clk); exitAck = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) pm[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    expectOut("R1 reset", 1'b0, 0, 8'h00);
    rstN = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk); prioRdId = 3'(i); #1;
      checks++;
      if (prioRdData !== 8'h00) begin
        errors++;
        $display("FAIL R1 prio reg %0d: actual=%02h expected=00", i, prioRdData);
      end
    end

    // R2: only top bits stored, read back
    for (int i = 0; i < N; i++) writePrio(i, 8'((7 - i) << 5) | 8'h1F);
    for (int i = 0; i < N; i++) begin
      prioRdId = 3'(i); #1;
      checks++;
      if (prioRdData !== pm[i]) begin
        errors++;
        $display("FAIL R2 prio reg %0d: actual=%02h expected=%02h", i, prioRdData, pm[i]);
      end
    end

    // R3 R8 R11: distinct priorities, all preempt, idle
    sweep("R3 R8 R11 distinct", 8'hFF);

    // R3 ties, subpriority grouping, threshold with ignored low bits (R4 R7)
    writePrio(0, 8'h40); writePrio(1, 8'h20); writePrio(2, 8'h40); writePrio(3, 8'h20);
    writePrio(4, 8'h60); writePrio(5, 8'h20); writePrio(6, 8'hE0); writePrio(7, 8'h5F);
    groupSel = 3'd6; thresh = 8'h7F;
    sweep("R3 R4 R7 ties+threshold", 8'hF7);

    // R7: effective threshold 0 means no masking
    thresh = 8'h1F; groupSel = 3'd0;
    sweep("R7 zero threshold", 8'hFF);

    // R7: tight threshold, some zero priorities
    writePrio(2, 8'h00); writePrio(6, 8'h00);
    thresh = 8'h20;
    sweep("R7 tight threshold", 8'hBF);

    // R6: global disable
    thresh = 8'h00; globalMask = 1'b1;
    sweep("R6 global mask", 8'hFF);
    globalMask = 1'b0;

    // Nesting: group 6 -> preempt bits 7:6, subpriority bit 5
    irqEnable = 8'hFF; groupSel = 3'd6;
    writePrio(0, 8'h80); writePrio(1, 8'h40); writePrio(2, 8'h60);
    writePrio(3, 8'h20); writePrio(4, 8'h00);
    setPend(8'h01); expectOut("R8 idle take", 1'b1, 0, 8'h80);
    pulseEntry;
    @(negedge clk); expectOut("R4 equal level no preempt", 1'b0, 0, 8'h00);
    setPend(8'h05); expectOut("R4 more urgent preempts", 1'b1, 2, 8'h60);
    pulseEntry;
    setPend(8'h06); expectOut("R5 subpriority no preempt", 1'b0, 0, 8'h00);
    setPend(8'h08); expectOut("R4 preempt level 0 preempts", 1'b1, 3, 8'h20);
    pulseEntry;
    setPend(8'h10); expectOut("R4 level 0 blocks all", 1'b0, 0, 8'h00);
    pulseExit; expectOut("R10 restored 40 allows 00", 1'b1, 4, 8'h00);
    setPend(8'h02); expectOut("R10 restored 40 blocks 40", 1'b0, 0, 8'h00);
    pulseExit; expectOut("R10 restored 80 allows 40", 1'b1, 1, 8'h40);
    setPend(8'h01); expectOut("R10 restored 80 blocks 80", 1'b0, 0, 8'h00);
    pulseExit; expectOut("R10 idle allows 80", 1'b1, 0, 8'h80);
    pulseExit; expectOut("R10 exit on empty stays idle", 1'b1, 0, 8'h80);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule